// File: doc/BRIEF.md
# Length-Checked SPI Register Slave

This block is an SPI target that gives a host access to a small bank of 8-bit registers. Each transaction is a 16-bit frame. The first byte is a command: a 2-bit operation code followed by a 6-bit address. The second byte carries write data, or a byte the slave ignores on reads. While the host clocks the frame in, the slave sends its reply in the same frame. The first reply byte is a status byte. The second is the addressed register's content, taken before any update.

The slave runs entirely in the system clock domain. It samples SCK, chip select and MOSI through synchronizers, so SCK must run well below the system clock. At the end of every chip-select window the slave checks how many SCK rising edges arrived. A frame of the wrong length commits nothing and latches a sticky error bit. A complete frame whose bits are all zero is taken as a data line stuck low, and it resets the register bank.

Top module: `spi_fc_slave`

## Requirements
- R1: SPI mode 0 with active-low `csn`. MOSI is taken on SCK rising edges, MSB first. The frame is op[1:0], then address A5..A0, then 8 data bits. SDO changes after SCK falling edges, and the first reply bit is valid before the first rising edge.
- R2: Op 00 (write) to address 1..NUM_REGS-1 stores the data byte when chip select rises after exactly 16 rising edges. The second reply byte is the content before the write.
- R3: Op 01 (read) returns the addressed register's current content in the second reply byte. The data byte the host sends is ignored: the register keeps its value.
- R4: Address 0 always reads DEV_ID, and a write to it has no effect. Addresses from NUM_REGS to 63 read 0x00, and writes to them change nothing.
- R5: Ops 10 and 11 change no register. Their second reply byte is 0x00.
- R6: In the status byte, bit 7 is the communication-error flag as it stood when chip select fell. Bits 6..0 are 0.
- R7: A frame whose rising-edge count is not 16 sets the communication-error flag and discards its write. On a read, the register is still shifted out.
- R8: A short frame simply stops the reply early. In a long frame, every SDO bit after the 16th is 0.
- R9: The error flag stays set until a frame of exactly 16 edges ends. The status byte of that clearing frame still shows the flag set.
- R10: A 16-edge frame whose bits are all 0 resets registers 1..NUM_REGS-1 to 0x00 and clears the error flag, and its write decode is suppressed. An all-zero frame of the wrong length triggers no reset.
- R11: `sdo_oe` is high only while the synchronized chip select is low. While `sdo_oe` is low, `sdo` is 0.
- R12: Synchronous active-low `rst_n` clears all writable registers and the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI serial clock from the host |
| csn | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial reply data, 0 while not enabled |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |

## Verification
Two actions can fall on the same end-of-frame cycle: the device reset from an all-zero frame and the register write decode. An all-zero 16-bit frame is also, formally, a write to address 0. The bench sends that frame after registers hold non-zero data, and then reads those registers back, expecting zero and a clear status bit. In the same way, the error-flag set and the write commit are decided together at chip-select release. Short and long write frames are followed by reads that must show the old content and a set error bit.

// File: rtl/spi_fc_pkg.sv
// Package: protocol constants and the operation code type shared by the
// SPI register slave. The frame layout is fixed by the protocol, so these
// are localparams rather than module parameters.
package spi_fc_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 8;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 6;
    localparam int OP_W       = 2;
    localparam int CNT_W      = $clog2(2 * FRAME_BITS);
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [OP_W-1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_RSV_A = 2'b10,
        OP_RSV_B = 2'b11
    } op_e;
endpackage

// File: rtl/spi_fc_sync.sv
// Module: spi_fc_sync
// Brings the asynchronous SPI pins into the clk domain through STAGES
// flops and derives single-cycle edge pulses.
// Assumes SCK high and low phases each last several clk periods.
module spi_fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csn,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_start,
    output logic cs_end,
    output logic mosi_s
);
    // bit 0 = sck, bit 1 = csn, bit 2 = mosi; idle value has csn high
    localparam logic [2:0] IDLE = 3'b010;

    logic [STAGES-1:0][2:0] stg;
    logic [1:0]             prev_q;
    logic [2:0]             last;

    // first synchronizer stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= IDLE;
        else        stg[0] <= {mosi, csn, sck};
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // further synchronizer stages
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= IDLE;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign last = stg[STAGES-1];

    // remembers previous synchronized sck and csn for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE[1:0];
        else        prev_q <= last[1:0];
    end

    assign cs_act   = ~last[1];
    assign cs_start = ~last[1] &  prev_q[1];
    assign cs_end   =  last[1] & ~prev_q[1];
    assign sck_rise = cs_act &  last[0] & ~prev_q[0];
    assign sck_fall = cs_act & ~last[0] &  prev_q[0];
    assign mosi_s   = last[2];
endmodule

// File: rtl/spi_fc_shifter.sv
// Module: spi_fc_shifter
// Counts SCK rising edges per chip-select window, collects the incoming
// frame, latches the command byte and serializes the in-frame reply
// (status byte, then reply byte, then zeros).
// Assumes edge pulses come from spi_fc_sync and are never simultaneous.
module spi_fc_shifter
    import spi_fc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sck_rise,
    input  logic                  sck_fall,
    input  logic                  cs_start,
    input  logic                  mosi_s,
    input  logic [DATA_W-1:0]     status_byte,
    input  logic [DATA_W-1:0]     reply_byte,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic [FRAME_BITS-1:0] rx_frame,
    output logic [CMD_BITS-1:0]   cmd_q,
    output logic                  sdo_bit
);
    logic [CNT_W-1:0]      pos_q;
    logic [DATA_W-1:0]     status_q;
    logic [DATA_W-1:0]     reply_q;
    logic                  load_q;
    logic [FRAME_BITS-1:0] out_word;

    // receive shift register and saturating rising-edge counter
    always_ff @(posedge clk) begin
        if (!rst_n || cs_start) begin
            bit_cnt  <= '0;
            rx_frame <= '0;
        end else if (sck_rise) begin
            if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt < CNT_W'(FRAME_BITS)) rx_frame <= {rx_frame[FRAME_BITS-2:0], mosi_s};
        end
    end

    // captures the command byte on the 8th rising edge, flags reply load
    always_ff @(posedge clk) begin
        if (!rst_n || cs_start) begin
            cmd_q  <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (sck_rise && bit_cnt == CNT_W'(CMD_BITS - 1)) begin
                cmd_q  <= {rx_frame[CMD_BITS-2:0], mosi_s};
                load_q <= 1'b1;
            end
        end
    end

    // holds the two reply bytes: status at frame start, data after command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            reply_q  <= '0;
        end else if (cs_start) begin
            status_q <= status_byte;
            reply_q  <= '0;
        end else if (load_q) begin
            reply_q  <= reply_byte;
        end
    end

    // output bit position, advanced on each SCK falling edge
    always_ff @(posedge clk) begin
        if (!rst_n || cs_start)           pos_q <= '0;
        else if (sck_fall && pos_q != '1) pos_q <= pos_q + 1'b1;
    end

    assign out_word = {status_q, reply_q};

    // selects the current reply bit, zero beyond the frame
    always_comb begin
        if (pos_q < CNT_W'(FRAME_BITS))
            sdo_bit = out_word[IDX_W'(FRAME_BITS - 1) - pos_q[IDX_W-1:0]];
        else
            sdo_bit = 1'b0;
    end
endmodule

// File: rtl/spi_fc_regbank.sv
// Module: spi_fc_regbank
// Register file: address 0 is a constant identity value, 1..NUM_REGS-1
// are read/write, the rest read as zero. Also holds the sticky
// communication-error flag.
// Assumes wr_en is only raised for writable addresses.
module spi_fc_regbank
    import spi_fc_pkg::*;
#(
    parameter int                NUM_REGS = 8,
    parameter logic [DATA_W-1:0] DEV_ID   = 8'hC3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             dev_rst,
    input  logic                             err_set,
    input  logic                             err_clr,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             comm_err,
    output logic [(NUM_REGS-1)*DATA_W-1:0]   regs_flat
);
    logic [NUM_REGS-1:1][DATA_W-1:0] store;

    // writable registers, cleared by reset or by a device reset frame
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst) begin
            store <= '0;
        end else if (wr_en) begin
            for (int i = 1; i < NUM_REGS; i++)
                if (wr_addr == ADDR_W'(i)) store[i] <= wr_data;
        end
    end

    // sticky communication-error flag
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst) comm_err <= 1'b0;
        else if (err_set)      comm_err <= 1'b1;
        else if (err_clr)      comm_err <= 1'b0;
    end

    // read multiplexer with identity at 0 and zero for unused addresses
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = DEV_ID;
        for (int i = 1; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = store[i];
    end

    genvar g;
    generate
        for (g = 1; g < NUM_REGS; g++) begin : g_flat
            assign regs_flat[(g-1)*DATA_W +: DATA_W] = store[g];
        end
    endgenerate
endmodule

// File: rtl/spi_fc_slave.sv
// Module: spi_fc_slave (top)
// SPI mode-0 register slave with in-frame reply, frame-length checking
// and all-zero-frame device reset. Decodes the frame at chip-select
// release and drives the register bank.
// Assumes SCK is much slower than clk (several clk periods per phase).
module spi_fc_slave
    import spi_fc_pkg::*;
#(
    parameter int                NUM_REGS    = 8,
    parameter logic [DATA_W-1:0] DEV_ID      = 8'hC3,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csn,
    input  logic mosi,
    output logic sdo,
    output logic sdo_oe
);
    logic                           sck_rise, sck_fall, cs_act, cs_start, cs_end, mosi_s;
    logic [CNT_W-1:0]               bit_cnt;
    logic [FRAME_BITS-1:0]          rx_frame;
    logic [CMD_BITS-1:0]            cmd_q;
    logic                           sdo_bit;
    logic [DATA_W-1:0]              rd_data, status_byte, reply_byte;
    logic                           comm_err;
    logic [(NUM_REGS-1)*DATA_W-1:0] regs_flat;
    logic                           frame_ok, all_zero, dev_rst, wr_en, err_set;
    op_e                            cmd_op, frame_op;
    logic [ADDR_W-1:0]              rd_addr, wr_addr;

    spi_fc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
        .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
    );

    spi_fc_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_start(cs_start), .mosi_s(mosi_s), .status_byte(status_byte),
        .reply_byte(reply_byte), .bit_cnt(bit_cnt), .rx_frame(rx_frame),
        .cmd_q(cmd_q), .sdo_bit(sdo_bit)
    );

    // command-phase decode feeding the reply byte
    assign cmd_op      = op_e'(cmd_q[CMD_BITS-1 -: OP_W]);
    assign rd_addr     = cmd_q[ADDR_W-1:0];
    assign status_byte = {comm_err, {(DATA_W-1){1'b0}}};
    assign reply_byte  = (cmd_op == OP_WRITE || cmd_op == OP_READ) ? rd_data : '0;

    // end-of-frame decode: length check, zero-frame reset, write commit
    assign frame_op = op_e'(rx_frame[FRAME_BITS-1 -: OP_W]);
    assign wr_addr  = rx_frame[DATA_W +: ADDR_W];
    assign frame_ok = cs_end && (bit_cnt == CNT_W'(FRAME_BITS));
    assign all_zero = (rx_frame == '0);
    assign dev_rst  = frame_ok && all_zero;
    assign err_set  = cs_end && (bit_cnt != CNT_W'(FRAME_BITS));
    assign wr_en    = frame_ok && !all_zero && frame_op == OP_WRITE
                      && wr_addr != '0 && wr_addr < ADDR_W'(NUM_REGS);

    spi_fc_regbank #(.NUM_REGS(NUM_REGS), .DEV_ID(DEV_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(rx_frame[DATA_W-1:0]), .dev_rst(dev_rst), .err_set(err_set),
        .err_clr(frame_ok), .rd_addr(rd_addr), .rd_data(rd_data),
        .comm_err(comm_err), .regs_flat(regs_flat)
    );

    // pad-side outputs
    assign sdo_oe = cs_act;
    assign sdo    = cs_act & sdo_bit;
endmodule

// File: rtl/spi_fc_chk.sv
// Module: spi_fc_chk
// Property checker bound into spi_fc_slave.
module spi_fc_chk
    import spi_fc_pkg::*;
#(
    parameter int                NUM_REGS = 8,
    parameter logic [DATA_W-1:0] DEV_ID   = 8'hC3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sdo,
    input logic                           sdo_oe,
    input logic                           frame_end,
    input logic [CNT_W-1:0]               bit_cnt,
    input logic                           comm_err,
    input logic                           dev_rst,
    input logic [(NUM_REGS-1)*DATA_W-1:0] regs_flat,
    input logic [ADDR_W-1:0]              rd_addr,
    input logic [DATA_W-1:0]              rd_data
);
    // R11
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R7
    len_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bit_cnt != CNT_W'(FRAME_BITS)) |=> comm_err);

    // R9
    len_err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bit_cnt == CNT_W'(FRAME_BITS)) |=> !comm_err);

    // R10
    zero_frame_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |=> (regs_flat == '0));

    // R4
    unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= ADDR_W'(NUM_REGS)) |-> (rd_data == '0));

    // R4
    id_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_data == DEV_ID));
endmodule

bind spi_fc_slave spi_fc_chk #(.NUM_REGS(NUM_REGS), .DEV_ID(DEV_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .frame_end(cs_end),
    .bit_cnt(bit_cnt), .comm_err(comm_err), .dev_rst(dev_rst),
    .regs_flat(regs_flat), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_spi_fc_slave.sv
module tb_spi_fc_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic csn = 1'b1;
    logic mosi = 1'b0;
    logic sdo, sdo_oe;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    spi_fc_slave dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // entry: {nbits[4:0], mosi[23:0], expected sdo[23:0], requirement[7:0]}
    localparam int NV = 25;
    localparam logic [60:0] VEC [NV] = '{
        {5'd16, 24'h004000, 24'h0000C3, 8'd4},  // R4 identity
        {5'd16, 24'h00039E, 24'h000000, 8'd2},  // R2 write reg3
        {5'd16, 24'h004300, 24'h00009E, 8'd3},  // R3 read reg3
        {5'd16, 24'h000311, 24'h00009E, 8'd2},  // R2 prior content
        {5'd16, 24'h0043FF, 24'h000011, 8'd3},  // R3 data byte ignored
        {5'd16, 24'h004300, 24'h000011, 8'd3},  // R3 unchanged
        {5'd16, 24'h000077, 24'h0000C3, 8'd4},  // R4 write to id
        {5'd16, 24'h004000, 24'h0000C3, 8'd4},  // R4 id intact
        {5'd16, 24'h002A55, 24'h000000, 8'd4},  // R4 unused write
        {5'd16, 24'h006A00, 24'h000000, 8'd4},  // R4 unused read
        {5'd16, 24'h008322, 24'h000000, 8'd5},  // R5 op 10
        {5'd16, 24'h00C3AA, 24'h000000, 8'd5},  // R5 op 11
        {5'd16, 24'h004300, 24'h000011, 8'd5},  // R5 no change
        {5'd12, 24'h000035, 24'h000001, 8'd8},  // R8 short, truncated
        {5'd16, 24'h004300, 24'h008011, 8'd9},  // R9 flag seen, write dropped
        {5'd16, 24'h004300, 24'h000011, 8'd9},  // R9 cleared
        {5'd16, 24'h00073C, 24'h000000, 8'd2},  // R2 write reg7
        {5'd20, 24'h047000, 24'h0003C0, 8'd8},  // R8 long, zero tail
        {5'd20, 24'h007990, 24'h0803C0, 8'd7},  // R7 long write
        {5'd16, 24'h004700, 24'h00803C, 8'd7},  // R7 write discarded
        {5'd8,  24'h000000, 24'h000000, 8'd10}, // R10 short zero frame
        {5'd16, 24'h004700, 24'h00803C, 8'd10}, // R10 no reset
        {5'd16, 24'h000000, 24'h0000C3, 8'd10}, // R10 zero frame
        {5'd16, 24'h004300, 24'h000000, 8'd10}, // R10 reg3 cleared
        {5'd16, 24'h004700, 24'h000000, 8'd10}  // R10 reg7 cleared
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one SPI mode-0 frame; rx collects sdo sampled before each rising edge
    task automatic spi_frame(input int nbits, input logic [23:0] tx,
                             output logic [23:0] rx, output logic oe_ok);
        rx    = '0;
        oe_ok = 1'b1;
        csn   = 1'b0;
        wait_clk(8);
        for (int i = 0; i < nbits; i++) begin
            mosi = tx[nbits-1-i];
            wait_clk(8);
            rx = {rx[22:0], sdo};
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
            sck = 1'b1;
            wait_clk(8);
            sck = 1'b0;
        end
        wait_clk(8);
        csn  = 1'b1;
        mosi = 1'b0;
        wait_clk(12);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        logic [23:0] got;
        logic        oe;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R11 R12: idle state after reset
        check("R11 idle oe", {23'd0, sdo_oe}, 24'h0);
        check("R11 idle sdo", {23'd0, sdo}, 24'h0);

        // R1 R6: first frame, status clear and identity readable
        spi_frame(16, 24'h004000, got, oe);
        check("R1 frame", got, 24'h0000C3);
        check("R11 oe in frame", {23'd0, oe}, 24'h1);

        for (int k = 0; k < NV; k++) begin
            logic [4:0]  nb;
            logic [23:0] tx, ex;
            logic [7:0]  rq;
            {nb, tx, ex, rq} = VEC[k];
            spi_frame(int'(nb), tx, got, oe);
            check($sformatf("R%0d vec %0d", rq, k), got, ex);
        end

        // R12: hardware reset clears registers and the error flag
        spi_frame(16, 24'h000566, got, oe);
        spi_frame(16, 24'h004500, got, oe);
        check("R2 reg5 written", got, 24'h000066);
        spi_frame(6, 24'h000011, got, oe);
        @(negedge clk) rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        spi_frame(16, 24'h004500, got, oe);
        check("R12 reg5 and flag after reset", got, 24'h000000);

        // R6 R7: zero-clock chip-select pulse counts as wrong length
        csn = 1'b0;
        wait_clk(10);
        csn = 1'b1;
        wait_clk(12);
        spi_frame(16, 24'h004000, got, oe);
        check("R6 flag bit position", got, 24'h0080C3);
        check("R11 idle after frame", {22'd0, sdo_oe, sdo}, 24'h0);

        done = 1'b1;
        finish_run();
    end
endmodule